// File: doc/BRIEF.md
# Port Output Register with Set/Reset

This block holds the data side of a 16-pin general-purpose port behind a small memory-mapped bus. A read/write output register drives the pins. A read-only input register captures the pin levels on every clock. A write-only set/reset location lets software raise or drop any chosen output bits in a single bus write, so no read-modify-write sequence is needed and nothing can intervene between the read and the write.

The bus carries a write strobe, a read strobe, a byte address, 32-bit write data with four byte-lane enables, and registered 32-bit read data. Read data appears on the clock edge after the edge that sampled the read strobe. Writes take effect on the edge that samples the write strobe. Direct writes to the output register and set/reset writes use different addresses, so the two never arrive in the same cycle.

Top module: `port_out_reg`

## Requirements
- R1: After a synchronous reset `pin_out` is 0x0000, and a read of the output register at offset 0x14 returns 0x00000000.
- R2: A write to offset 0x14 updates output bit i from write-data bit i for every byte lane whose enable is high (lane 0 covers bits 7:0, lane 1 covers bits 15:8). Disabled lanes keep their value, and bits 31:16 of the write are discarded.
- R3: In a write to offset 0x18, write-data bit i (i in 0..15) equal to 1 forces output bit i to 1. A 0 in any position of that write leaves the matching output bit unchanged.
- R4: In a write to offset 0x18, write-data bit i+16 equal to 1 forces output bit i to 0.
- R5: When one write to offset 0x18 has both bit i and bit i+16 set, output bit i ends at 1.
- R6: Byte-lane enables gate set/reset writes: only enabled lanes contribute set or clear bits. A half-word write to the upper half (lanes 2 and 3) therefore only clears bits.
- R7: A set/reset write acts once. A later direct write to offset 0x14 replaces any bit that the set/reset write changed.
- R8: A read of offset 0x10 returns the pin levels sampled on the clock edge before the read strobe was captured, with bits 31:16 zero. Writes to 0x10 change neither the input register nor the outputs.
- R9: Reads of offset 0x18 and of any unmapped offset return zero. Bits 31:16 of read data are always zero, and read data is valid one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Pin levels to be sampled |
| pin_out | output | 16 | Output value driven to the pins |

## Verification
The assertions check on every cycle that a set/reset write leaves every requested set bit high and every clear-only bit low, that the outputs hold steady when no output write occurs, and that read data of the upper half, of the set/reset location and of the input location follow the rules for their addresses. Lane gating of direct writes, the way a half-word upper write clears without setting, and a direct write overriding an earlier set/reset write can only be shown by the bench's sequences of writes and the output values they leave behind.

// File: rtl/port_reg_pkg.sv
package port_reg_pkg;
  parameter int unsigned ADDR_W_DEF = 8;
  parameter logic [7:0]  OFS_IN     = 8'h10;
  parameter logic [7:0]  OFS_OUT    = 8'h14;
  parameter logic [7:0]  OFS_SETCLR = 8'h18;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_IN   = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_SC   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/port_in_sampler.sv
module port_in_sampler #(
  parameter int unsigned PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] in_q
);
  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= pin_in;
  end
endmodule

// File: rtl/port_odr_core.sv
module port_odr_core #(
  parameter int unsigned PINS   = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_direct,
  input  logic              wr_sc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output logic [PINS-1:0]   odr_q
);
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] wd_gated;
  logic [PINS-1:0]   set_m;
  logic [PINS-1:0]   clr_m;
  logic [PINS-1:0]   direct_next;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*8 +: 8] = {8{be[l]}};
  end

  assign wd_gated    = wdata & lane_mask;
  assign set_m       = wd_gated[PINS-1:0];
  assign clr_m       = wd_gated[2*PINS-1:PINS];
  assign direct_next = (odr_q & ~lane_mask[PINS-1:0]) | wd_gated[PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst)            odr_q <= '0;
    else if (wr_direct) odr_q <= direct_next;
    else if (wr_sc)     odr_q <= (odr_q & ~clr_m) | set_m;
  end

  AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (rst)
    wr_sc |=> ((odr_q & $past(set_m)) == $past(set_m)));                // R3
  AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_sc && ((clr_m & ~set_m) != '0)) |=> ((odr_q & $past(clr_m & ~set_m)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_sc && ((set_m & clr_m) != '0)) |=> ((odr_q & $past(set_m & clr_m)) == $past(set_m & clr_m))); // R5
  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_sc && (set_m == '0) && (clr_m == '0)) |=> $stable(odr_q));     // R6
  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_direct && !wr_sc) |=> $stable(odr_q));                        // R8
endmodule

// File: rtl/port_rd_mux.sv
module port_rd_mux
  import port_reg_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [PINS-1:0]   in_q,
  input  logic [PINS-1:0]   odr_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_IN:  rd_next[PINS-1:0] = in_q;
      SEL_OUT: rd_next[PINS-1:0] = odr_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  AST_SC_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_SC) |=> (rdata == '0));                       // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> (rdata == '0));                     // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));                                        // R9
endmodule

// File: rtl/port_out_reg.sv
module port_out_reg
  import port_reg_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out
);
  reg_sel_e        sel;
  logic [PINS-1:0] in_q;
  logic [PINS-1:0] odr_q;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_IN))     sel = SEL_IN;
    else if (bus_addr == ADDR_W'(OFS_OUT))    sel = SEL_OUT;
    else if (bus_addr == ADDR_W'(OFS_SETCLR)) sel = SEL_SC;
    else                                      sel = SEL_NONE;
  end

  port_in_sampler #(.PINS(PINS)) u_in (
    .clk(clk), .rst(rst), .pin_in(pin_in), .in_q(in_q)
  );

  port_odr_core #(.PINS(PINS), .DATA_W(DATA_W)) u_odr (
    .clk(clk), .rst(rst),
    .wr_direct(bus_wr && sel == SEL_OUT),
    .wr_sc(bus_wr && sel == SEL_SC),
    .wdata(bus_wdata), .be(bus_be), .odr_q(odr_q)
  );

  port_rd_mux #(.PINS(PINS), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .sel(sel),
    .in_q(in_q), .odr_q(odr_q), .rdata(bus_rdata)
  );

  assign pin_out = odr_q;

  AST_UPPER_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:PINS] == '0);                                   // R9
  AST_IN_READ_PINS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_IN) |=> (bus_rdata[PINS-1:0] == $past(pin_in, 2))); // R8
  AST_OUT_READ_PINS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_OUT) |=> (bus_rdata[PINS-1:0] == $past(pin_out))); // R1
endmodule

// File: tb/port_out_reg_tb.sv
module port_out_reg_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  port_out_reg dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out)
  );

  // {addr[59:52], be[51:48], wdata[47:16], expected pin_out[15:0]}
  localparam int NV = 12;
  localparam logic [59:0] VEC [NV] = '{
    {8'h14, 4'hF, 32'h0000_A5C3, 16'hA5C3}, // R2 full direct write
    {8'h18, 4'hF, 32'h0000_0018, 16'hA5DB}, // R3 set bits 3,4
    {8'h18, 4'hF, 32'h00C0_0000, 16'hA51B}, // R4 clear bits 6,7
    {8'h18, 4'hF, 32'h0004_0004, 16'hA51F}, // R5 set and clear bit 2
    {8'h18, 4'hC, 32'hFF00_00FF, 16'h001F}, // R6 upper half-word: clears only
    {8'h18, 4'h1, 32'h0000_FF20, 16'h003F}, // R6 byte lane 0 only
    {8'h14, 4'h2, 32'h0000_7700, 16'h773F}, // R2 byte lane 1 only
    {8'h14, 4'hF, 32'hFFFF_0000, 16'h0000}, // R2 upper bits discarded
    {8'h18, 4'hF, 32'h0000_8001, 16'h8001}, // R3 set bits 0,15
    {8'h14, 4'hF, 32'h0000_1234, 16'h1234}, // R7 direct write after set/reset
    {8'h10, 4'hF, 32'h0000_FFFF, 16'h1234}, // R8 write to input offset ignored
    {8'h18, 4'hF, 32'h0000_0000, 16'h1234}  // R3 all zero: no change
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pin_out after reset", {16'h0, pin_out}, 32'h0);
    bus_read(8'h14, rd);
    check("R1 output reg read after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][59:52], VEC[i][51:48], VEC[i][47:16]);
      check($sformatf("vector %0d (R2..R8 per table)", i), {16'h0, pin_out}, {16'h0, VEC[i][15:0]});
    end

    // R2 readback of output register, upper bits zero
    bus_read(8'h14, rd);
    check("R2 output reg readback", rd, 32'h0000_1234);

    // R9 set/reset location reads zero
    bus_read(8'h18, rd);
    check("R9 set/reset reads zero", rd, 32'h0);
    bus_read(8'h3C, rd);
    check("R9 unmapped offset reads zero", rd, 32'h0);

    // R8 input sampling, two patterns
    @(negedge clk); pin_in = 16'hBEEF;
    bus_read(8'h10, rd);
    check("R8 input read pattern 1", rd, 32'h0000_BEEF);
    @(negedge clk); pin_in = 16'h4001;
    bus_read(8'h10, rd);
    check("R8 input read pattern 2", rd, 32'h0000_4001);
    bus_write(8'h10, 4'hF, 32'hFFFF_0000);
    bus_read(8'h10, rd);
    check("R8 input unaffected by write", rd, 32'h0000_4001);

    // R5 set wins on every bit at once
    bus_write(8'h18, 4'hF, 32'hFFFF_FFFF);
    check("R5 all set and clear", {16'h0, pin_out}, 32'h0000_FFFF);
    // R4 clear all
    bus_write(8'h18, 4'hF, 32'hFFFF_0000);
    check("R4 clear all", {16'h0, pin_out}, 32'h0);
    // R6 lane 3 only clears bits 15:8
    bus_write(8'h14, 4'hF, 32'h0000_FFFF);
    bus_write(8'h18, 4'h8, 32'hFFFF_FFFF);
    check("R6 lane 3 clears high byte", {16'h0, pin_out}, 32'h0000_00FF);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 pin_out after second reset", {16'h0, pin_out}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule